// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Sequencer

This block owns the descriptor table of a 10/100 Ethernet MAC and walks it on behalf of the frame sender and the frame receiver. The table is one on-chip memory of descriptors. Each descriptor is two 32-bit words: a status/control word, then a buffer address word. A programmable count splits the table. The transmit ring takes the entries from zero up to that count, and the receive ring takes the entries that follow. Neither ring has a fixed length. A ring closes at the first descriptor whose wrap flag is set.

A host reaches three control registers and the table over a simple single-cycle register bus. The transmit side offers a ready descriptor to the sender through a request/done handshake and writes the reported status back. The receive side accepts a one-cycle frame-arrival pulse, with its length and error flags, into the current empty descriptor. Completions raise sticky interrupt-source bits. The host clears these bits by writing ones.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset, `tx_req_o` and `irq_o` are low and the interrupt-source register (offset 0x004) reads 0.
- R2: The descriptor table starts at byte offset 0x400. Descriptor n has its status word at 0x400+8n and its address word at 0x400+8n+4. Host writes to either word read back unchanged.
- R3: The transmit count register (offset 0x008) reads back the written value clamped to 128. The first receive descriptor is the table entry whose index equals that count, and its address word is shown on `rx_buf_o`.
- R4: When transmit is enabled (bit 1 of offset 0x000), a descriptor is handed to the sender only if its ready bit (status bit 15) is set. `tx_req_o` then presents the length (bits 31:16), the buffer address, pad enable (bit 12) and CRC enable (bit 11), and holds until `tx_done_i`.
- R5: On `tx_done_i`, the status word gets ready cleared and bits 8:0 replaced by `tx_status_i`. All other bits are kept.
- R6: When receive is enabled (bit 0 of offset 0x000), an arriving frame is stored only in an empty descriptor (status bit 15 set). Bits 31:16 get `rx_len_i`, which counts the 4-byte frame check sequence. Bits 8:0 get `rx_status_i`, and the empty bit is cleared.
- R7: After a descriptor is finished, its ring pointer returns to the first entry of that ring if wrap (status bit 13) was set. Otherwise the pointer moves to the next entry.
- R8: Frame completion bits are raised only if the descriptor's interrupt enable (status bit 14) is set. For transmit, bit 1 is raised if any of the status flags 0, 2, 3 or 8 is set, and bit 0 otherwise. For receive, bit 3 is raised if any status flag 7:0 is set, bit 6 if only flag 8 (control frame) is set, and bit 2 otherwise. `irq_o` is the OR of all interrupt-source bits.
- R9: Writing a one to an interrupt-source bit clears it. If a bit is set and acknowledged in the same cycle, the set wins.
- R10: A frame that arrives while the current receive descriptor is not empty is dropped. The descriptor is left unchanged, the pointer stays where it is, and bit 4 is set whatever the interrupt enable.
- R11: A write to the transmit count register sends both ring pointers back to the start of their rings. Clearing an enable bit sends that ring's pointer back to the start. While receive is disabled, arriving frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register bus write strobe |
| reg_addr_i | input | 12 | Register bus byte address |
| reg_wdata_i | input | 32 | Register bus write data |
| reg_rdata_o | output | 32 | Register bus read data (combinational) |
| tx_req_o | output | 1 | Descriptor offered to frame sender |
| tx_len_o | output | 16 | Frame length of offered descriptor |
| tx_buf_o | output | 32 | Buffer address of offered descriptor |
| tx_pad_o | output | 1 | Pad enable of offered descriptor |
| tx_crc_o | output | 1 | CRC enable of offered descriptor |
| tx_done_i | input | 1 | Sender finished the offered frame |
| tx_status_i | input | 9 | Transmit completion flags |
| rx_frame_i | input | 1 | One-cycle pulse: a received frame is complete |
| rx_len_i | input | 16 | Received length including FCS |
| rx_status_i | input | 9 | Receive error and control-frame flags |
| rx_buf_o | output | 32 | Buffer address of current receive descriptor |
| irq_o | output | 1 | OR of interrupt-source bits |

## Verification
A receive completion and a host acknowledge of the interrupt-source register can land in the same cycle. The bench provokes this by driving a frame-arrival pulse and a write of one to the receive-frame bit on the same clock edge. It passes only if that bit reads back as set afterwards. Transmit completions go through a scoreboard that compares every offered descriptor against a queue of expected ones. This also shows the ring wrap and the pointer reset that a count write causes.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int STAT_W = 9;
  localparam int IRQ_N  = 7;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_IRQ   = 12'h004;
  localparam logic [11:0] OFS_TXNUM = 12'h008;
  localparam logic [11:0] OFS_TABLE = 12'h400;

  // status word bit positions
  localparam int B_OWN  = 15;  // tx ready / rx empty
  localparam int B_IE   = 14;
  localparam int B_WRAP = 13;
  localparam int B_PAD  = 12;
  localparam int B_CRC  = 11;
  localparam int B_CTLF = 8;

  localparam logic [STAT_W-1:0] TX_ERR_MASK = 9'h10D;
  localparam logic [STAT_W-1:0] RX_ERR_MASK = 9'h0FF;

  // interrupt-source bit positions
  localparam int I_TXF  = 0;
  localparam int I_TXE  = 1;
  localparam int I_RXF  = 2;
  localparam int I_RXE  = 3;
  localparam int I_BUSY = 4;
  localparam int I_TXC  = 5;
  localparam int I_RXC  = 6;
endpackage

// File: rtl/bd_ring_ptr.sv
module bd_ring_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             wrap_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ptr_o <= '0;
    else if (clr_i)               ptr_o <= '0;
    else if (step_i && wrap_i)    ptr_o <= '0;
    else if (step_i)              ptr_o <= ptr_o + 1'b1;
  end

  p_step_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i) |=> (ptr_o == '0) || (ptr_o == PTR_W'($past(ptr_o) + 1'b1)));
endmodule

// File: rtl/bd_tx_ctl.sv
module bd_tx_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ready_i,
  input  logic done_i,
  output logic req_o,
  output logic fin_o
);
  logic req_d;

  assign fin_o = req_o & done_i & en_i;

  always_comb begin
    req_d = req_o;
    if (!en_i)                 req_d = 1'b0;
    else if (fin_o)            req_d = 1'b0;
    else if (!req_o && ready_i) req_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= req_d;
  end

  p_req_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i && en_i) |=> req_o);
  p_req_needs_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(ready_i && en_i));
endmodule

// File: rtl/bd_irq_src.sv
module bd_irq_src #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] src_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       src_o[i] <= 1'b0;
      else if (set_i[i]) src_o[i] <= 1'b1;  // set beats acknowledge
      else if (clr_i[i]) src_o[i] <= 1'b0;
    end
  end

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((src_o & $past(set_i)) == $past(set_i)));
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((src_o & $past(src_o & ~clr_i)) == $past(src_o & ~clr_i)));
endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq
  import bd_pkg::*;
#(
  parameter int DESC_NUM = 256,
  parameter int TX_MAX   = 128,
  parameter int ADDR_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              tx_req_o,
  output logic [15:0]       tx_len_o,
  output logic [31:0]       tx_buf_o,
  output logic              tx_pad_o,
  output logic              tx_crc_o,
  input  logic              tx_done_i,
  input  logic [STAT_W-1:0] tx_status_i,
  input  logic              rx_frame_i,
  input  logic [15:0]       rx_len_i,
  input  logic [STAT_W-1:0] rx_status_i,
  output logic [31:0]       rx_buf_o,
  output logic              irq_o
);
  localparam int WORDS  = 2 * DESC_NUM;
  localparam int IDX_W  = $clog2(DESC_NUM);
  localparam int WIDX_W = IDX_W + 1;
  localparam int CNT_W  = $clog2(TX_MAX) + 1;

  logic [31:0]       mem_q [WORDS];
  logic              rx_en_q, tx_en_q;
  logic [CNT_W-1:0]  tx_num_q;
  logic [IDX_W-1:0]  tx_ptr, rx_ptr, rx_idx;
  logic [IRQ_N-1:0]  irq_set, irq_clr, irq_q;
  logic [31:0]       tx_stat, rx_stat, tx_wb, rx_wb;
  logic              tbl_sel, num_we, tx_fin, rx_hit, rx_ok, rx_drop;
  logic              tx_err, rx_err, rx_ctl;
  logic [WIDX_W-1:0] host_widx;

  // host decode
  assign tbl_sel   = reg_addr_i >= ADDR_W'(OFS_TABLE);
  assign host_widx = WIDX_W'((reg_addr_i - ADDR_W'(OFS_TABLE)) >> 2);
  assign num_we    = reg_we_i && reg_addr_i == ADDR_W'(OFS_TXNUM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      tx_num_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_W'(OFS_CTRL)) begin
        rx_en_q <= reg_wdata_i[0];
        tx_en_q <= reg_wdata_i[1];
      end
      if (num_we)
        tx_num_q <= (reg_wdata_i > 32'(TX_MAX)) ? CNT_W'(TX_MAX) : reg_wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (tbl_sel)                                 reg_rdata_o = mem_q[host_widx];
    else if (reg_addr_i == ADDR_W'(OFS_CTRL))    reg_rdata_o = {30'b0, tx_en_q, rx_en_q};
    else if (reg_addr_i == ADDR_W'(OFS_IRQ))     reg_rdata_o = 32'(irq_q);
    else if (reg_addr_i == ADDR_W'(OFS_TXNUM))   reg_rdata_o = 32'(tx_num_q);
  end

  // transmit side
  assign tx_stat  = mem_q[{tx_ptr, 1'b0}];
  assign tx_buf_o = mem_q[{tx_ptr, 1'b1}];
  assign tx_len_o = tx_stat[31:16];
  assign tx_pad_o = tx_stat[B_PAD];
  assign tx_crc_o = tx_stat[B_CRC];
  assign tx_err   = |(tx_status_i & TX_ERR_MASK);

  bd_tx_ctl u_tx_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_en_q),
    .ready_i(tx_stat[B_OWN]),
    .done_i (tx_done_i),
    .req_o  (tx_req_o),
    .fin_o  (tx_fin)
  );

  always_comb begin
    tx_wb              = tx_stat;
    tx_wb[B_OWN]       = 1'b0;
    tx_wb[STAT_W-1:0]  = tx_status_i;
  end

  bd_ring_ptr #(.PTR_W(IDX_W)) u_tx_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (num_we || !tx_en_q),
    .step_i(tx_fin),
    .wrap_i(tx_stat[B_WRAP]),
    .ptr_o (tx_ptr)
  );

  // receive side
  assign rx_idx   = IDX_W'(tx_num_q) + rx_ptr;
  assign rx_stat  = mem_q[{rx_idx, 1'b0}];
  assign rx_buf_o = mem_q[{rx_idx, 1'b1}];
  assign rx_hit   = rx_frame_i && rx_en_q;
  assign rx_ok    = rx_hit && rx_stat[B_OWN];
  assign rx_drop  = rx_hit && !rx_stat[B_OWN];
  assign rx_err   = |(rx_status_i & RX_ERR_MASK);
  assign rx_ctl   = rx_status_i[B_CTLF];

  always_comb begin
    rx_wb              = rx_stat;
    rx_wb[31:16]       = rx_len_i;
    rx_wb[B_OWN]       = 1'b0;
    rx_wb[STAT_W-1:0]  = rx_status_i;
  end

  bd_ring_ptr #(.PTR_W(IDX_W)) u_rx_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (num_we || !rx_en_q),
    .step_i(rx_ok),
    .wrap_i(rx_stat[B_WRAP]),
    .ptr_o (rx_ptr)
  );

  // table: engine write-backs are placed after the host write
  always_ff @(posedge clk_i) begin
    if (reg_we_i && tbl_sel) mem_q[host_widx] <= reg_wdata_i;
    if (tx_fin)              mem_q[{tx_ptr, 1'b0}] <= tx_wb;
    if (rx_ok)               mem_q[{rx_idx, 1'b0}] <= rx_wb;
  end

  // interrupt sources
  always_comb begin
    irq_set         = '0;
    irq_set[I_TXF]  = tx_fin && tx_stat[B_IE] && !tx_err;
    irq_set[I_TXE]  = tx_fin && tx_stat[B_IE] && tx_err;
    irq_set[I_RXF]  = rx_ok && rx_stat[B_IE] && !rx_err && !rx_ctl;
    irq_set[I_RXE]  = rx_ok && rx_stat[B_IE] && rx_err;
    irq_set[I_RXC]  = rx_ok && rx_stat[B_IE] && !rx_err && rx_ctl;
    irq_set[I_BUSY] = rx_drop;
    irq_set[I_TXC]  = 1'b0;
  end
  assign irq_clr = (reg_we_i && reg_addr_i == ADDR_W'(OFS_IRQ)) ? reg_wdata_i[IRQ_N-1:0] : '0;

  bd_irq_src #(.N(IRQ_N)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (irq_set),
    .clr_i (irq_clr),
    .src_o (irq_q)
  );
  assign irq_o = |irq_q;

  p_drop_holds_ptr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_drop && !num_we) |=> $stable(rx_ptr));
  p_drop_raises_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop |=> irq_q[I_BUSY]);
  p_rx_off_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_q && !num_we) |=> (rx_ptr == '0));
endmodule

// File: tb/tb_bd_ring_seq.sv
`timescale 1ns/1ps
module tb_bd_ring_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_req, tx_pad, tx_crc, irq;
  logic [15:0] tx_len;
  logic [31:0] tx_buf, rx_buf;
  logic        tx_done = 1'b0;
  logic [8:0]  tx_status = '0;
  logic        rx_frame = 1'b0;
  logic [15:0] rx_len = '0;
  logic [8:0]  rx_status = '0;

  int n_run = 0;
  int n_fail = 0;

  typedef struct packed {
    logic [15:0] len;
    logic [31:0] buf_a;
    logic        pad;
    logic        crc;
    logic [8:0]  st;
  } tx_item_t;
  tx_item_t exp_q[$];

  always #2 clk = ~clk;

  bd_ring_seq dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_req_o(tx_req), .tx_len_o(tx_len), .tx_buf_o(tx_buf), .tx_pad_o(tx_pad), .tx_crc_o(tx_crc),
    .tx_done_i(tx_done), .tx_status_i(tx_status),
    .rx_frame_i(rx_frame), .rx_len_i(rx_len), .rx_status_i(rx_status),
    .rx_buf_o(rx_buf), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic frame(input logic [15:0] l, input logic [8:0] s);
    @(negedge clk);
    rx_frame = 1'b1; rx_len = l; rx_status = s;
    @(negedge clk);
    rx_frame = 1'b0;
  endtask

  task automatic expect_tx(input logic [15:0] l, input logic [31:0] a, input logic p,
                           input logic c, input logic [8:0] s);
    exp_q.push_back({l, a, p, c, s});
  endtask

  task automatic wait_tx(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || tx_req) && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk({req, " tx queue drained"}, 32'(exp_q.size()), 32'd0);
  endtask

  // scoreboard monitor: compares each offered descriptor, then answers done
  initial begin
    forever begin
      @(negedge clk);
      if (tx_req) begin
        tx_item_t it;
        if (exp_q.size() == 0) begin
          chk("R4 unexpected tx offer", 32'(tx_len), 32'hFFFF_FFFF);
          it = '0;
        end else begin
          it = exp_q.pop_front();
          chk("R4 tx len", 32'(tx_len), 32'(it.len));
          chk("R4 tx buf", tx_buf, it.buf_a);
          chk("R4 tx pad/crc", {30'b0, tx_pad, tx_crc}, {30'b0, it.pad, it.crc});
        end
        repeat (2) @(negedge clk);
        chk("R4 req held until done", 32'(tx_req), 32'd1);
        tx_done = 1'b1; tx_status = it.st;
        @(negedge clk);
        tx_done = 1'b0; tx_status = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(12'h004, d);
    chk("R1 irq source", d, 32'h0);
    chk("R1 outputs", {30'b0, tx_req, irq}, 32'h0);

    // R3 clamp
    wr(12'h008, 32'd200);
    rd(12'h008, d);
    chk("R3 count clamp", d, 32'd128);
    wr(12'h008, 32'd2);
    rd(12'h008, d);
    chk("R3 count", d, 32'd2);

    // R2 table access; tx descriptors 0 and 1
    wr(12'h400, 32'h0064_C800);
    wr(12'h404, 32'h0000_1000);
    wr(12'h408, 32'h0028_F000);
    wr(12'h40C, 32'h0000_2000);
    rd(12'h40C, d);
    chk("R2 addr word readback", d, 32'h0000_2000);
    rd(12'h408, d);
    chk("R2 status word readback", d, 32'h0028_F000);

    // R4 not ready while disabled: nothing offered
    repeat (3) @(negedge clk);
    chk("R4 no offer while disabled", 32'(tx_req), 32'd0);

    // R4/R5/R8 transmit two frames
    expect_tx(16'd100, 32'h1000, 1'b0, 1'b1, 9'h010);
    expect_tx(16'd40,  32'h2000, 1'b1, 1'b0, 9'h004);
    wr(12'h000, 32'h2);
    wait_tx("R4");
    rd(12'h400, d);
    chk("R5 tx writeback ok", d, 32'h0064_4810);
    rd(12'h408, d);
    chk("R5 tx writeback err", d, 32'h0028_7004);
    rd(12'h004, d);
    chk("R8 tx irq bits", d, 32'h3);
    chk("R8 irq_o", 32'(irq), 32'd1);

    // R7 wrap: desc1 had wrap, desc0 goes again
    expect_tx(16'd100, 32'h1000, 1'b0, 1'b1, 9'h000);
    wr(12'h400, 32'h0064_C800);
    wait_tx("R7");

    // R9 write-one-to-clear
    wr(12'h004, 32'h1);
    rd(12'h004, d);
    chk("R9 partial clear", d, 32'h2);
    wr(12'h004, 32'h2);
    rd(12'h004, d);
    chk("R9 full clear", d, 32'h0);
    chk("R9 irq_o low", 32'(irq), 32'd0);

    // R11 count write resets tx pointer (now at 1); R8 no irq without enable
    wr(12'h008, 32'd2);
    expect_tx(16'd100, 32'h1000, 1'b0, 1'b1, 9'h000);
    wr(12'h400, 32'h0064_8800);
    wait_tx("R11");
    rd(12'h004, d);
    chk("R8 no irq when disabled in descriptor", d, 32'h0);

    // receive ring at entries 2,3
    wr(12'h410, 32'h0000_C000);
    wr(12'h414, 32'h0000_3000);
    wr(12'h418, 32'h0000_E000);
    wr(12'h41C, 32'h0000_4000);
    wr(12'h000, 32'h3);
    @(negedge clk);
    chk("R3 rx ring starts after tx", rx_buf, 32'h3000);

    frame(16'd68, 9'h000);
    rd(12'h410, d);
    chk("R6 rx fill", d, 32'h0044_4000);
    rd(12'h004, d);
    chk("R8 rx frame bit", d, 32'h4);
    chk("R7 rx advance", rx_buf, 32'h4000);

    frame(16'd1518, 9'h002);
    rd(12'h418, d);
    chk("R6 rx fill with error", d, 32'h05EE_6002);
    rd(12'h004, d);
    chk("R8 rx error bit", d, 32'hC);
    chk("R7 rx wrap", rx_buf, 32'h3000);

    // R10 drop on full descriptor
    frame(16'd90, 9'h000);
    rd(12'h410, d);
    chk("R10 descriptor untouched", d, 32'h0044_4000);
    rd(12'h004, d);
    chk("R10 busy bit", d, 32'h1C);
    chk("R10 pointer held", rx_buf, 32'h3000);

    // R9 set and acknowledge in the same cycle
    wr(12'h004, 32'h7F);
    wr(12'h410, 32'h0000_C000);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h4;
    rx_frame = 1'b1; rx_len = 16'd64; rx_status = 9'h000;
    @(negedge clk);
    reg_we = 1'b0; rx_frame = 1'b0;
    rd(12'h004, d);
    chk("R9 set wins over clear", d, 32'h4);
    wr(12'h004, 32'h7F);

    // R11 rx disable resets pointer and ignores frames
    chk("R11 rx pointer before disable", rx_buf, 32'h4000);
    wr(12'h000, 32'h2);
    @(negedge clk);
    chk("R11 rx pointer reset", rx_buf, 32'h3000);
    wr(12'h410, 32'h0000_8000);
    frame(16'd70, 9'h000);
    rd(12'h410, d);
    chk("R11 frame ignored while disabled", d, 32'h0000_8000);
    rd(12'h004, d);
    chk("R11 no irq while disabled", d, 32'h0);
    wr(12'h000, 32'h3);
    frame(16'd80, 9'h000);
    rd(12'h410, d);
    chk("R6 fill without irq enable", d, 32'h0050_0000);
    rd(12'h004, d);
    chk("R8 rx no irq without enable", d, 32'h0);

    // R8 control frame
    wr(12'h418, 32'h0000_E000);
    frame(16'd64, 9'h100);
    rd(12'h004, d);
    chk("R8 rx control bit", d, 32'h40);
    rd(12'h418, d);
    chk("R6 control frame fill", d, 32'h0040_6100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule